// File: doc/BRIEF.md
# Tile Distributor with Quad Masking

This block sits between a triangle setup stage and four quad pixel pipelines. Each quad pipeline holds four pixel pipelines. Setup delivers screen tiles as a valid/ready stream. Each tile carries a triangle number, the tile's X and Y position, and a flag that marks the final tile of its triangle. The distributor passes each tile to exactly one quad through that quad's own valid/ready port. It rotates among the quads whose enable bit is set. Quads that fail production test can therefore be fused off, and the part still runs with one, two, three or four quads. Tiles of one triangle may land on different quads.

Software supplies a four-bit quad enable mask and a two-bit tile size code on configuration inputs. The block takes a new value of either one only at a triangle boundary, so every tile of a triangle uses the same quad set and the same tile size. Each delivered tile carries the size code it was accepted under, and also the tile edge in pixels.

The control is a three-state machine:
- ST_IDLE: no tile is held.
- ST_SEND: one tile is held and offered to its target quad.
- ST_HALT: the enable mask is empty.

The machine has five transitions:
- IDLE→SEND when a tile is accepted.
- SEND→IDLE when the target quad takes the tile.
- IDLE→HALT when the latched mask is zero.
- HALT→IDLE when a non-zero mask is latched.
- Every state stays where it is otherwise.

Top module: `td_dispatch`

## Requirements
- R1: After reset, no output valid is high, `cfg_err` is low, `in_ready` is high, and the latched mask is all four quads enabled. The next search starts at quad 0.
- R2: A tile is never delivered to a quad whose bit in the latched enable mask is clear. Mask bit i enables quad i.
- R3: Tiles go round-robin over the enabled quads. After a tile is delivered to quad n, the next tile goes to the first enabled quad found in the order n+1, n+2, ... wrapping past 3 back to 0.
- R4: At most one output valid is high in any cycle. An accepted tile appears on its quad's valid in the cycle after acceptance.
- R5: While the target quad holds its ready low, the block keeps that quad's valid high and holds the payload stable. It does not redirect the tile to another quad, and `in_ready` stays low.
- R6: When the latched mask is zero, `in_ready` stays low and `cfg_err` is raised. A later non-zero mask clears `cfg_err` and resumes distribution.
- R7: A change on the mask or size inputs takes effect only at a triangle boundary. That is, it applies only after a tile with `in_last` set has been accepted, or when no triangle is in progress since reset.
- R8: Size code 0, 1, 2 and 3 mean tile edges of 8, 16, 32 and 64 pixels. `out_size` and `out_edge` report the code and the edge in force when the tile was accepted.
- R9: The triangle number, X and Y of a tile reach the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mask | input | NUM_QUADS | Quad enable mask requested by software |
| cfg_size | input | 2 | Tile size code requested by software |
| in_valid | input | 1 | Incoming tile valid |
| in_ready | output | 1 | Distributor can accept a tile |
| in_tri | input | TRI_W | Triangle number of the tile |
| in_x | input | COORD_W | Tile X position |
| in_y | input | COORD_W | Tile Y position |
| in_last | input | 1 | Final tile of its triangle |
| out_valid | output | NUM_QUADS | Per-quad tile valid |
| out_ready | input | NUM_QUADS | Per-quad ready |
| out_tri | output | TRI_W | Triangle number of the offered tile |
| out_x | output | COORD_W | X of the offered tile |
| out_y | output | COORD_W | Y of the offered tile |
| out_size | output | 2 | Size code of the offered tile |
| out_edge | output | 7 | Tile edge in pixels |
| cfg_err | output | 1 | No quad enabled |

## Verification
The bench drives sparse masks such as 1010 and a single quad. A picker that rotated over all four quads would hand tiles to fused quads, and one that restarted at quad 0 would never balance the load. It changes the mask and size in the middle of a triangle. A design that latched them at once would send the remaining tiles of that triangle to the new quad set with the new size. It stalls a target quad for several cycles. A design that skipped a busy quad would move the tile or let its payload drift. It also clears every enable bit and then restores one. A design without the halt state would either hang or accept tiles it can never deliver.

// File: rtl/td_pkg.sv
package td_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_HALT = 2'd2
    } td_state_e;

    localparam int EDGE_W = 7;

    function automatic logic [EDGE_W-1:0] edge_of(input logic [1:0] code);
        return 7'd8 << code;
    endfunction
endpackage

// File: rtl/td_cfg_hold.sv
module td_cfg_hold #(
    parameter int NUM_QUADS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [NUM_QUADS-1:0] mask_i,
    input  logic [1:0]           size_i,
    output logic [NUM_QUADS-1:0] mask_o,
    output logic [1:0]           size_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '1;
            size_o <= 2'd0;
        end else if (load_i) begin
            mask_o <= mask_i;
            size_o <= size_i;
        end
    end
endmodule

// File: rtl/td_rr_pick.sv
module td_rr_pick #(
    parameter int NUM_QUADS = 4,
    localparam int QW = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1
) (
    input  logic [NUM_QUADS-1:0] mask_i,
    input  logic [QW-1:0]        start_i,
    output logic [QW-1:0]        pick_o,
    output logic                 any_o
);
    logic [QW-1:0]        cand [NUM_QUADS];
    logic [NUM_QUADS-1:0] rot;

    for (genvar g = 0; g < NUM_QUADS; g++) begin : g_rot
        logic [QW:0] sum;
        assign sum     = {1'b0, start_i} + (QW+1)'(g);
        assign cand[g] = (sum >= (QW+1)'(NUM_QUADS)) ? QW'(sum - (QW+1)'(NUM_QUADS)) : QW'(sum);
        assign rot[g]  = mask_i[cand[g]];
    end

    always_comb begin
        pick_o = start_i;
        for (int i = NUM_QUADS - 1; i >= 0; i--) begin
            if (rot[i]) pick_o = cand[i];
        end
    end

    assign any_o = |mask_i;
endmodule

// File: rtl/td_dispatch.sv
module td_dispatch #(
    parameter int NUM_QUADS = 4,
    parameter int TRI_W     = 16,
    parameter int COORD_W   = 12,
    localparam int QW = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_QUADS-1:0] cfg_mask,
    input  logic [1:0]           cfg_size,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [TRI_W-1:0]     in_tri,
    input  logic [COORD_W-1:0]   in_x,
    input  logic [COORD_W-1:0]   in_y,
    input  logic                 in_last,
    output logic [NUM_QUADS-1:0] out_valid,
    input  logic [NUM_QUADS-1:0] out_ready,
    output logic [TRI_W-1:0]     out_tri,
    output logic [COORD_W-1:0]   out_x,
    output logic [COORD_W-1:0]   out_y,
    output logic [1:0]           out_size,
    output logic [6:0]           out_edge,
    output logic                 cfg_err
);
    import td_pkg::*;

    td_state_e            state, state_nx;
    logic [NUM_QUADS-1:0] act_mask;
    logic [1:0]           act_size;
    logic                 cfg_open;
    logic                 cfg_load;
    logic [QW-1:0]        next_start;
    logic [QW-1:0]        pick;
    logic                 any_en;
    logic [QW-1:0]        tgt;
    logic                 accept;
    logic                 handoff;

    assign accept   = in_valid && in_ready;
    assign handoff  = (state == ST_SEND) && out_ready[tgt];
    assign cfg_load = cfg_open && (state != ST_SEND) && !accept;

    td_cfg_hold #(.NUM_QUADS(NUM_QUADS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load),
        .mask_i (cfg_mask),
        .size_i (cfg_size),
        .mask_o (act_mask),
        .size_o (act_size)
    );

    td_rr_pick #(.NUM_QUADS(NUM_QUADS)) u_pick (
        .mask_i  (act_mask),
        .start_i (next_start),
        .pick_o  (pick),
        .any_o   (any_en)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!any_en)       state_nx = ST_HALT;
                else if (in_valid) state_nx = ST_SEND;
            end
            ST_SEND: if (out_ready[tgt]) state_nx = ST_IDLE;
            ST_HALT: if (any_en)         state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = '0;
        cfg_err   = 1'b0;
        unique case (state)
            ST_IDLE: in_ready       = any_en;
            ST_SEND: out_valid[tgt] = 1'b1;
            ST_HALT: cfg_err        = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt        <= '0;
            next_start <= '0;
            cfg_open   <= 1'b1;
            out_tri    <= '0;
            out_x      <= '0;
            out_y      <= '0;
            out_size   <= 2'd0;
        end else begin
            if (accept) begin
                tgt      <= pick;
                cfg_open <= in_last;
                out_tri  <= in_tri;
                out_x    <= in_x;
                out_y    <= in_y;
                out_size <= act_size;
            end
            if (handoff) begin
                next_start <= (tgt == QW'(NUM_QUADS - 1)) ? '0 : tgt + 1'b1;
            end
        end
    end

    assign out_edge = edge_of(out_size);
endmodule

// File: rtl/td_dispatch_chk.sv
module td_dispatch_chk #(
    parameter int NUM_QUADS = 4,
    parameter int TRI_W     = 16,
    parameter int COORD_W   = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_ready,
    input logic [NUM_QUADS-1:0] out_valid,
    input logic [NUM_QUADS-1:0] out_ready,
    input logic [TRI_W-1:0]     out_tri,
    input logic [COORD_W-1:0]   out_x,
    input logic [COORD_W-1:0]   out_y,
    input logic                 cfg_err,
    input logic [NUM_QUADS-1:0] act_mask,
    input logic                 cfg_open
);
    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R2
    fused_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & ~act_mask) == '0);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & ~out_ready) != '0) |=> (out_valid == $past(out_valid))
            && $stable(out_tri) && $stable(out_x) && $stable(out_y) && !in_ready);

    // R6
    halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !in_ready && (out_valid == '0));

    // R7
    mid_tri_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(act_mask));
endmodule

bind td_dispatch td_dispatch_chk #(
    .NUM_QUADS (NUM_QUADS),
    .TRI_W     (TRI_W),
    .COORD_W   (COORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tri   (out_tri),
    .out_x     (out_x),
    .out_y     (out_y),
    .cfg_err   (cfg_err),
    .act_mask  (act_mask),
    .cfg_open  (cfg_open)
);

// File: tb/td_dispatch_tb.sv
`timescale 1ns/1ps
module td_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_mask = 4'hF;
    logic [1:0]  cfg_size = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_tri = '0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic        in_last = 1'b0;
    logic [3:0]  out_valid;
    logic [3:0]  out_ready = 4'hF;
    logic [15:0] out_tri;
    logic [11:0] out_x;
    logic [11:0] out_y;
    logic [1:0]  out_size;
    logic [6:0]  out_edge;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    int bptr   = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    td_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_size(cfg_size),
        .in_valid(in_valid), .in_ready(in_ready), .in_tri(in_tri), .in_x(in_x),
        .in_y(in_y), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_tri(out_tri), .out_x(out_x), .out_y(out_y), .out_size(out_size),
        .out_edge(out_edge), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_pick(input logic [3:0] m);
        for (int i = 0; i < 4; i++) begin
            if (m[(bptr + i) % 4]) return (bptr + i) % 4;
        end
        return -1;
    endfunction

    task automatic set_cfg(input logic [3:0] m, input logic [1:0] s);
        @(negedge clk);
        cfg_mask = m;
        cfg_size = s;
        @(negedge clk);
    endtask

    task automatic push(input int t, input int x, input int y, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_tri   = 16'(t);
        in_x     = 12'(x);
        in_y     = 12'(y);
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_chk(input int t, input int x, input int y, input bit last,
                            input logic [3:0] m, input int edge_px, input string req);
        int q;
        q = model_pick(m);
        push(t, x, y, last);
        check(out_valid == 4'(1 << q), req, "target quad valid", int'(out_valid), 1 << q);
        check(out_tri == 16'(t) && out_x == 12'(x) && out_y == 12'(y), "R9",
              "payload tri", int'(out_tri), t);
        check(out_edge == 7'(edge_px), "R8", "tile edge", int'(out_edge), edge_px);
        bptr = (q + 1) % 4;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(out_valid == 4'h0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(cfg_err == 1'b0, "R1", "cfg_err after reset", int'(cfg_err), 0);
    endtask

    task automatic t_rotate_all;
        // R3 full mask: 0,1,2,3,0
        for (int i = 0; i < 5; i++) send_chk(10 + i, i, 2 * i, 1'b1, 4'hF, 8, "R3");
    endtask

    task automatic t_sparse;
        // R2 mask 1010 only quads 1 and 3
        set_cfg(4'b1010, 2'd1);
        for (int i = 0; i < 4; i++) send_chk(20, 100 + i, 7, 1'b1, 4'b1010, 16, "R2");
        // R2 single quad 0
        set_cfg(4'b0001, 2'd2);
        for (int i = 0; i < 3; i++) send_chk(30 + i, i, 1, 1'b1, 4'b0001, 32, "R2");
        // R3 three quads 1101
        set_cfg(4'b1101, 2'd3);
        for (int i = 0; i < 4; i++) send_chk(40, i, 3, 1'b1, 4'b1101, 64, "R3");
    endtask

    task automatic t_stall;
        int q;
        set_cfg(4'hF, 2'd0);
        q = model_pick(4'hF);
        out_ready = 4'h0;
        push(55, 77, 88, 1'b1);
        for (int i = 0; i < 3; i++) begin
            check(out_valid == 4'(1 << q), "R5", "held valid", int'(out_valid), 1 << q);
            check(!in_ready && out_x == 12'd77, "R5", "held payload x", int'(out_x), 77);
            @(negedge clk);
        end
        out_ready = 4'hF;
        @(negedge clk);
        check(out_valid == 4'h0, "R5", "released after ready", int'(out_valid), 0);
        bptr = (q + 1) % 4;
    endtask

    task automatic t_boundary;
        set_cfg(4'hF, 2'd1);
        send_chk(60, 1, 1, 1'b0, 4'hF, 16, "R7");
        set_cfg(4'b1000, 2'd3);
        send_chk(60, 2, 1, 1'b0, 4'hF, 16, "R7");
        send_chk(60, 3, 1, 1'b1, 4'hF, 16, "R7");
        @(negedge clk);
        send_chk(61, 4, 1, 1'b1, 4'b1000, 64, "R7");
        check(out_size == 2'd3, "R8", "size code", int'(out_size), 3);
    endtask

    task automatic t_zero;
        set_cfg(4'b0000, 2'd0);
        @(negedge clk);
        check(cfg_err == 1'b1, "R6", "cfg_err with empty mask", int'(cfg_err), 1);
        check(in_ready == 1'b0, "R6", "in_ready with empty mask", int'(in_ready), 0);
        set_cfg(4'b0100, 2'd0);
        @(negedge clk);
        check(cfg_err == 1'b0, "R6", "cfg_err cleared", int'(cfg_err), 0);
        send_chk(70, 5, 5, 1'b1, 4'b0100, 8, "R6");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rotate_all();
        t_sparse();
        t_stall();
        t_boundary();
        t_zero();
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule